// File: doc/BRIEF.md
# VLIW Packet Boundary Parser

This block sits behind an instruction fetch stream of a wide-issue processor. It accepts one 32-bit instruction word per cycle over a valid/ready handshake and gathers the words into execution packets of one to four words. All grouping decisions come from a 2-bit marker field at bits [15:14] of every word. What that field means depends on where the word sits in the packet, and for one code value it also depends on the word's class field at bits [31:28].

When a packet closes, the block presents all of it at once on a parallel output. The output carries the words in arrival order, the word count, a kind tag for each word, a widened immediate for any word that follows a constant extender, and flags for inner-loop end and outer-loop end. The output is held until the consumer takes it. While a packet waits, the input is stalled. A malformed stream forces the open packet to close and sets a sticky error flag. Decoding beyond the marker and class fields is left to downstream stages.

Top module: `bundle_framer`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `err_malformed` is 0.
- R2: A word whose marker field [15:14] is 2'b11 closes the packet, and a word with 2'b01 leaves it open. Slot i of `out_words` (bits [32i+31:32i]) holds the i-th word of the packet. `out_count` gives the number of words, 1 to 4.
- R3: A word with marker 2'b00 and a nonzero class field [31:28] is a compressed dual-operation word, tagged kind 2. It always closes the packet.
- R4: A word with marker 2'b00 and class field 0 is a constant extender, tagged kind 1. It never closes the packet. Every other word is tagged kind 0. The tag of slot i sits at `out_kind[2i+1:2i]`.
- R5: A word that directly follows an extender in the same packet gets `out_imm` slot i = {extender[25:0], word[5:0]}, with `out_imm_vld[i]` set. All other slots show an immediate of 0 and a clear valid bit.
- R6: Marker 2'b10 does not close the packet. On slot 0 it sets `out_loop_inner`, and on slot 1 it sets `out_loop_outer`. Both flags may be set together. On slots 2 and 3 it sets neither flag.
- R7: If the fourth word of a packet neither closes it normally nor is a dual-operation word, the packet closes with a count of 4 and `err_malformed` is set. This includes the case where the fourth word is an extender.
- R8: While `out_valid` is 1, `in_ready` is 0. A packet that is not yet consumed keeps all its output fields unchanged until the cycle in which `out_ready` is 1.
- R9: Once set, `err_malformed` stays set until reset. Parsing continues normally with the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can accept a word |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Completed packet present |
| out_ready | input | 1 | Consumer takes the packet |
| out_words | output | 128 | Packet words, slot 0 in the low bits |
| out_count | output | 3 | Words in the packet |
| out_kind | output | 8 | Per-slot kind: 0 operation, 1 extender, 2 dual |
| out_imm | output | 128 | Per-slot widened immediate |
| out_imm_vld | output | 4 | Per-slot widened-immediate valid |
| out_loop_inner | output | 1 | Inner-loop end marker seen |
| out_loop_outer | output | 1 | Outer-loop end marker seen |
| err_malformed | output | 1 | Sticky malformed-packet flag |

## Verification
If the slot counter goes wrong, the fault appears on the next packet to close: a wrong `out_count`, or a word placed in the wrong slot. If the extender carry flag goes wrong, the first word after it shows a wrong immediate in that same packet, and the error can even spill into the following packet when it is not cleared at the boundary. If the holding state goes wrong, `in_ready` or a changed output field shows it in the first stalled cycle. The bench models the stream behaviourally and compares every field on every cycle in which a packet is presented, so any such fault is reported within one packet.

// File: rtl/bundle_pkg.sv
package bundle_pkg;
    localparam int WORD_W   = 32;
    localparam int SLOTS    = 4;
    localparam int EXT_BITS = 26;

    localparam logic [1:0] MARK_SPECIAL = 2'b00;
    localparam logic [1:0] MARK_MORE    = 2'b01;
    localparam logic [1:0] MARK_LOOP    = 2'b10;
    localparam logic [1:0] MARK_LAST    = 2'b11;

    typedef enum logic [1:0] {
        KIND_OP   = 2'd0,
        KIND_EXT  = 2'd1,
        KIND_DUAL = 2'd2
    } kind_e;
endpackage

// File: rtl/bf_word_decode.sv
module bf_word_decode
    import bundle_pkg::*;
#(
    parameter int W       = WORD_W,
    parameter int MARK_LSB = 14,
    parameter int CLS_LSB  = 28,
    parameter int CLS_W    = 4
) (
    input  logic [W-1:0] word,
    output kind_e        kind,
    output logic         closes,
    output logic         loop_mark
);
    logic [1:0]       mark;
    logic [CLS_W-1:0] cls;

    always_comb begin
        mark      = word[MARK_LSB +: 2];
        cls       = word[CLS_LSB +: CLS_W];
        kind      = KIND_OP;
        closes    = 1'b0;
        loop_mark = 1'b0;
        unique case (mark)
            MARK_LAST: closes = 1'b1;
            MARK_LOOP: loop_mark = 1'b1;
            MARK_SPECIAL: begin
                if (cls == '0) begin
                    kind = KIND_EXT;
                end else begin
                    kind   = KIND_DUAL;
                    closes = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bf_imm_fold.sv
module bf_imm_fold
    import bundle_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int HI_W  = EXT_BITS,
    localparam int LO_W = W - HI_W
) (
    input  logic [HI_W-1:0] ext_payload,
    input  logic [W-1:0]    word,
    output logic [W-1:0]    imm
);
    assign imm = {ext_payload, word[LO_W-1:0]};
endmodule

// File: rtl/bundle_framer.sv
module bundle_framer
    import bundle_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int NSLOT = SLOTS,
    parameter int HI_W  = EXT_BITS,
    localparam int CNT_W = $clog2(NSLOT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [W-1:0]         in_word,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [NSLOT*W-1:0]   out_words,
    output logic [CNT_W-1:0]     out_count,
    output logic [NSLOT*2-1:0]   out_kind,
    output logic [NSLOT*W-1:0]   out_imm,
    output logic [NSLOT-1:0]     out_imm_vld,
    output logic                 out_loop_inner,
    output logic                 out_loop_outer,
    output logic                 err_malformed
);
    typedef struct packed {
        logic [NSLOT-1:0][W-1:0] words;
        logic [NSLOT-1:0][1:0]   kinds;
        logic [NSLOT-1:0][W-1:0] imm;
        logic [NSLOT-1:0]        imm_vld;
        logic [CNT_W-1:0]        cnt;
        logic                    inner;
        logic                    outer;
        logic                    carry_ext;
        logic [HI_W-1:0]         carry_bits;
        logic                    full;
        logic                    err;
    } frame_t;

    frame_t st_d, st_q;

    kind_e          w_kind;
    logic           w_closes;
    logic           w_loop;
    logic [W-1:0]   w_imm;
    logic           accept;
    logic           at_last;

    bf_word_decode #(.W(W)) u_dec (
        .word      (in_word),
        .kind      (w_kind),
        .closes    (w_closes),
        .loop_mark (w_loop)
    );

    bf_imm_fold #(.W(W), .HI_W(HI_W)) u_fold (
        .ext_payload (st_q.carry_bits),
        .word        (in_word),
        .imm         (w_imm)
    );

    always_comb begin
        st_d     = st_q;
        in_ready = !st_q.full;
        accept   = in_valid && !st_q.full;
        at_last  = (st_q.cnt == CNT_W'(NSLOT - 1));

        if (st_q.full && out_ready) begin
            st_d       = '0;
            st_d.err   = st_q.err;
        end

        if (accept) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (st_q.cnt == CNT_W'(i)) begin
                    st_d.words[i] = in_word;
                    st_d.kinds[i] = w_kind;
                    if (st_q.carry_ext) begin
                        st_d.imm[i]     = w_imm;
                        st_d.imm_vld[i] = 1'b1;
                    end
                end
            end
            if (w_loop && st_q.cnt == CNT_W'(0)) st_d.inner = 1'b1;
            if (w_loop && st_q.cnt == CNT_W'(1)) st_d.outer = 1'b1;
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (w_closes || at_last) begin
                st_d.full       = 1'b1;
                st_d.carry_ext  = 1'b0;
                st_d.carry_bits = '0;
                if (!w_closes) st_d.err = 1'b1;
            end else begin
                st_d.carry_ext  = (w_kind == KIND_EXT);
                st_d.carry_bits = in_word[HI_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid      = st_q.full;
    assign out_words      = st_q.words;
    assign out_count      = st_q.cnt;
    assign out_kind       = st_q.kinds;
    assign out_imm        = st_q.imm;
    assign out_imm_vld    = st_q.imm_vld;
    assign out_loop_inner = st_q.inner;
    assign out_loop_outer = st_q.outer;
    assign err_malformed  = st_q.err;
endmodule

// File: rtl/bundle_framer_chk.sv
module bundle_framer_chk #(
    parameter int W     = 32,
    parameter int NSLOT = 4,
    localparam int CNT_W = $clog2(NSLOT + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [NSLOT*W-1:0]   out_words,
    input logic [CNT_W-1:0]     out_count,
    input logic [NSLOT*2-1:0]   out_kind,
    input logic [NSLOT-1:0]     out_imm_vld,
    input logic                 out_loop_outer,
    input logic                 err_malformed
);
    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_count >= CNT_W'(1) && out_count <= CNT_W'(NSLOT)));

    assert_dual_first_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind[1:0] == 2'd2) |-> out_count == CNT_W'(1));

    assert_no_imm_slot0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_imm_vld[0]);

    assert_outer_needs_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_loop_outer) |-> out_count >= CNT_W'(2));

    assert_forced_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_malformed) |-> (out_valid && out_count == CNT_W'(NSLOT)));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_words) && $stable(out_count)));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_malformed |=> err_malformed);
endmodule

bind bundle_framer bundle_framer_chk #(.W(W), .NSLOT(NSLOT)) u_chk (.*);

// File: tb/bundle_framer_tb.sv
module bundle_framer_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_word = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_words;
    logic [2:0]   out_count;
    logic [7:0]   out_kind;
    logic [127:0] out_imm;
    logic [3:0]   out_imm_vld;
    logic         out_loop_inner;
    logic         out_loop_outer;
    logic         err_malformed;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;
    bit ready_hold_low = 0;

    always #5 clk = ~clk;

    bundle_framer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
        .out_words(out_words), .out_count(out_count), .out_kind(out_kind),
        .out_imm(out_imm), .out_imm_vld(out_imm_vld),
        .out_loop_inner(out_loop_inner), .out_loop_outer(out_loop_outer),
        .err_malformed(err_malformed)
    );

    typedef struct {
        logic [127:0] w;
        logic [2:0]   c;
        logic [7:0]   k;
        logic [127:0] imm;
        logic [3:0]   iv;
        logic         li;
        logic         lo;
    } pkt_t;

    pkt_t expq[$];
    pkt_t cur;
    bit   m_ext = 0;
    logic [31:0] m_prev = '0;
    bit   m_err = 0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] cls, input logic [1:0] mark, input logic [31:0] body);
        logic [31:0] r;
        r = body;
        r[31:28] = cls;
        r[15:14] = mark;
        return r;
    endfunction

    function automatic void clear_cur();
        cur.w = '0; cur.c = '0; cur.k = '0; cur.imm = '0; cur.iv = '0; cur.li = 0; cur.lo = 0;
    endfunction

    // behavioural stream model
    function automatic void model_word(input logic [31:0] w);
        int idx;
        int kind;
        bit endp;
        idx  = int'(cur.c);
        kind = (w[15:14] == 2'b00) ? ((w[31:28] == 4'd0) ? 1 : 2) : 0;
        endp = (w[15:14] == 2'b11) || (kind == 2);
        cur.w[idx*32 +: 32] = w;
        cur.k[idx*2 +: 2] = 2'(kind);
        if (m_ext) begin
            cur.imm[idx*32 +: 32] = {m_prev[25:0], w[5:0]};
            cur.iv[idx] = 1'b1;
        end
        if (w[15:14] == 2'b10 && idx == 0) cur.li = 1;
        if (w[15:14] == 2'b10 && idx == 1) cur.lo = 1;
        cur.c = cur.c + 3'd1;
        m_ext = (kind == 1);
        m_prev = w;
        if (endp || cur.c == 3'd4) begin
            if (!endp) m_err = 1;
            expq.push_back(cur);
            clear_cur();
            m_ext = 0;
        end
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(in_ready == (expq.size() == 0), "R8 in_ready", 128'(in_ready), 128'(expq.size() == 0));
            chk(out_valid == (expq.size() != 0), "R2 out_valid", 128'(out_valid), 128'(expq.size() != 0));
            chk(err_malformed == m_err, "R7 R9 err", 128'(err_malformed), 128'(m_err));
            if (out_valid && expq.size() != 0) begin
                chk(out_words == expq[0].w, "R2 words", out_words, expq[0].w);
                chk(out_count == expq[0].c, "R2 count", 128'(out_count), 128'(expq[0].c));
                chk(out_kind == expq[0].k, "R3 R4 kinds", 128'(out_kind), 128'(expq[0].k));
                chk(out_imm == expq[0].imm, "R5 imm", out_imm, expq[0].imm);
                chk(out_imm_vld == expq[0].iv, "R5 imm_vld", 128'(out_imm_vld), 128'(expq[0].iv));
                chk(out_loop_inner == expq[0].li, "R6 inner", 128'(out_loop_inner), 128'(expq[0].li));
                chk(out_loop_outer == expq[0].lo, "R6 outer", 128'(out_loop_outer), 128'(expq[0].lo));
                if (out_ready) void'(expq.pop_front());
            end
            if (in_valid && in_ready) model_word(in_word);
        end
    end

    always @(posedge clk) begin
        #1;
        out_ready = ready_hold_low ? 1'b0 : ($urandom_range(0, 3) != 0);
    end

    task automatic send(input logic [31:0] w);
        in_valid = 1'b1;
        in_word  = w;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_word  = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        clear_cur();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1 out_valid", 128'(out_valid), 128'(0));
        chk(in_ready == 1'b1, "R1 in_ready", 128'(in_ready), 128'(1));
        chk(err_malformed == 1'b0, "R1 err", 128'(err_malformed), 128'(0));
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R2 single, pair, quad
        send(mk(4'h1, 2'b11, 32'h0000_0011));
        send(mk(4'h2, 2'b01, 32'h0000_0021));
        send(mk(4'h3, 2'b11, 32'h0000_0022));
        send(mk(4'h4, 2'b01, 32'h0000_0031));
        send(mk(4'h5, 2'b01, 32'h0000_0032));
        send(mk(4'h6, 2'b01, 32'h0000_0033));
        send(mk(4'h7, 2'b11, 32'h0000_0034));
        // R3 dual alone and after an op
        send(mk(4'h9, 2'b00, 32'h0000_0041));
        send(mk(4'h2, 2'b01, 32'h0000_0051));
        send(mk(4'hA, 2'b00, 32'h0000_0052));
        // R4 R5 extender then op, extender then dual
        send(mk(4'h0, 2'b00, 32'h03AB_CDEF));
        send(mk(4'h1, 2'b11, 32'h0000_002A));
        send(mk(4'h0, 2'b00, 32'h0155_5555));
        send(mk(4'hB, 2'b00, 32'h0000_003F));
        // R6 inner, outer, both, late marker
        send(mk(4'h1, 2'b10, 32'h0000_0061));
        send(mk(4'h1, 2'b11, 32'h0000_0062));
        send(mk(4'h1, 2'b01, 32'h0000_0071));
        send(mk(4'h1, 2'b10, 32'h0000_0072));
        send(mk(4'h1, 2'b11, 32'h0000_0073));
        send(mk(4'h1, 2'b10, 32'h0000_0081));
        send(mk(4'h1, 2'b10, 32'h0000_0082));
        send(mk(4'h1, 2'b11, 32'h0000_0083));
        send(mk(4'h1, 2'b01, 32'h0000_0091));
        send(mk(4'h1, 2'b01, 32'h0000_0092));
        send(mk(4'h1, 2'b10, 32'h0000_0093));
        send(mk(4'h1, 2'b11, 32'h0000_0094));
        // R8 long stall on a waiting packet
        ready_hold_low = 1;
        send(mk(4'h3, 2'b11, 32'h0000_00A1));
        repeat (6) @(posedge clk);
        #1;
        ready_hold_low = 0;
        // R7 four words without close, then extender in last slot
        send(mk(4'h1, 2'b01, 32'h0000_00B1));
        send(mk(4'h1, 2'b01, 32'h0000_00B2));
        send(mk(4'h1, 2'b01, 32'h0000_00B3));
        send(mk(4'h1, 2'b01, 32'h0000_00B4));
        send(mk(4'h1, 2'b01, 32'h0000_00C1));
        send(mk(4'h1, 2'b01, 32'h0000_00C2));
        send(mk(4'h1, 2'b01, 32'h0000_00C3));
        send(mk(4'h0, 2'b00, 32'h0000_00C4));
        // R9 parsing continues, first word not widened
        send(mk(4'h1, 2'b11, 32'h0000_00D1));
        // random stream
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            if ($urandom_range(0, 3) == 0) r[31:28] = 4'h0;
            send(r);
        end
        send(mk(4'h1, 2'b11, 32'h0000_00E1));
        while (expq.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule